// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM with a 19-bit word address and an 8-bit data bus. A client raises a request with an address, a direction flag and write data. The controller accepts the request only while its ready output is high. It then drives the memory's address, its active-low chip select, output enable and write enable, and the data bus, so that every nanosecond limit of the memory is met. Each limit is given as a parameter in nanoseconds. A clock period parameter turns each limit into a whole number of cycles: the ceiling of the limit divided by the period, and never fewer than one.

A write opens with one cycle in which the chip is selected and its outputs are disabled. Next comes the write pulse, which ends when chip select and write enable rise together. The controller's data driver switches on only after a bus-release wait inside the pulse, and it stays on for one cycle after the pulse ends. Output enable stays high for the whole write. A read holds chip select and output enable low for the access time and samples the bus on the last access cycle. The read data comes back with a one-cycle valid pulse. A turnaround wait follows, because the memory can keep driving the bus after it is deselected. The memory is fully static, so the controller never runs maintenance cycles and can stay idle for any length of time.

The tri-state buffer itself lives at the chip pad. This block supplies the value to drive, the drive enable, and an input from the pad.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, write enable and output enable are high (1), the data drive enable is low, ready is high and the response valid flag is low.
- R2: A request is accepted only on a clock edge where ready is high. A request raised while ready is low has no effect on the memory contents. Ready goes low in the cycle after an accepted request.
- R3: The pins only ever take three patterns. Deselected is all three strobes high. A read is chip select low, output enable low and write enable high. A write is chip select low with write enable low or high and output enable high. Write enable is never low while chip select is high, and output enable and write enable are never low together.
- R4: The memory address does not change while chip select is low. In a write, write enable stays low for at least ceil(T_PWE/T) cycles, and chip select is low for at least ceil(T_AW/T) cycles before the pulse ends.
- R5: Write data is driven and unchanged for at least ceil(T_SD/T) cycles before the write pulse ends. It is still driven, with the same value, in the cycle after the pulse ends.
- R6: The controller never drives the data bus while output enable is low. It does not drive the bus within ceil(T_HZ/T) cycles after a read selection ends, or within the first ceil(T_HZ/T) cycles of a write pulse.
- R7: After a write, the next chip select falling edge comes at least ceil(T_WC/T) cycles after the one that began the write. Chip select stays low for exactly N_RA cycles in a read, where N_RA = max(ceil(T_RC/T), ceil(T_AA/T), ceil(T_DOE/T)).
- R8: Read data is sampled at the end of the last access cycle. It is returned with a one-cycle valid pulse that is high during the (N_RA+1)-th cycle after the accepting edge, and the value equals the most recent data written to that address.
- R9: Ready stays low for 1 + N_PW + N_REC cycles after a write is accepted, and for N_RA + 1 + ceil(T_HZ/T) cycles after a read is accepted. Here N_PW = max(ceil(T_PWE/T), ceil(T_HZ/T)+ceil(T_SD/T), ceil(T_AW/T)-1), and N_REC = max(1, ceil(T_WC/T)-1-N_PW).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Data for a write request |
| ready | output | 1 | High when a request can be taken |
| rsp_valid | output | 1 | One-cycle pulse marking returned read data |
| rsp_rdata | output | DATA_W | Captured read data, held until the next read |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Value for the pad driver |
| mem_dq_drive | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Value seen on the data pads |

## Verification
A phase counter that reloads with a wrong length shows up at once at the pins. A short write pulse or short data window is seen at the rising edge of write enable in that same write. A short read access returns stale or wrong data in the single valid cycle that follows. A state machine that leaves a phase early, or skips the turnaround, changes the number of cycles ready stays low, and the bench counts that on every transaction. A driver left on at the wrong time collides with the memory's output window within a few cycles of the strobe edge that caused it. A request latched while the controller is busy corrupts a location that the next read-back of that address exposes.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ASETUP   = 3'd1,
    ST_WPULSE   = 3'd2,
    ST_WRECOV   = 3'd3,
    ST_RACCESS  = 3'd4,
    ST_RRELEASE = 3'd5,
    ST_TURN     = 3'd6
  } seq_state_e;

  // Cycles needed to cover a limit in ns: rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned N_PW   = 1,
  parameter int unsigned N_REC  = 1,
  parameter int unsigned N_RA   = 1,
  parameter int unsigned N_TURN = 1,
  parameter int unsigned CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_write,
  output seq_state_e       state,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_last,
  output logic             accept,
  output logic             wr_end_evt,
  output logic             rd_capture_evt
);

  seq_state_e       nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;

  // Counter value loaded on entry to a phase: its length minus one.
  function automatic logic [CNT_W-1:0] entry_count(input seq_state_e s);
    case (s)
      ST_WPULSE:  return CNT_W'(N_PW - 1);
      ST_WRECOV:  return CNT_W'(N_REC - 1);
      ST_RACCESS: return CNT_W'(N_RA - 1);
      ST_TURN:    return CNT_W'(N_TURN - 1);
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (req) nxt = req_write ? ST_ASETUP : ST_RACCESS;
      ST_ASETUP:   nxt = ST_WPULSE;
      ST_WPULSE:   if (phase_last) nxt = ST_WRECOV;
      ST_WRECOV:   if (phase_last) nxt = ST_IDLE;
      ST_RACCESS:  if (phase_last) nxt = ST_RRELEASE;
      ST_RRELEASE: nxt = ST_TURN;
      ST_TURN:     if (phase_last) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign load     = (nxt != state);
  assign load_val = entry_count(nxt);

  assign accept         = (state == ST_IDLE) && req;
  assign wr_end_evt     = (state == ST_WPULSE) && phase_last;
  assign rd_capture_evt = (state == ST_RACCESS) && phase_last;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .last     (phase_last)
  );

endmodule

// File: rtl/sram_pin_decode.sv
`timescale 1ns/1ps
module sram_pin_decode
  import sram_seq_pkg::*;
#(
  parameter int unsigned N_PW  = 2,
  parameter int unsigned N_HZ  = 1,
  parameter int unsigned N_REC = 1,
  parameter int unsigned CNT_W = 4
) (
  input  seq_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drive
);

  // Pulse counter value at and below which the bus-release wait is over.
  localparam int unsigned DRV_LIMIT = N_PW - N_HZ - 1;

  always_comb begin
    cs_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    drive = 1'b0;
    case (state)
      ST_ASETUP: cs_n = 1'b0;
      ST_WPULSE: begin
        cs_n  = 1'b0;
        we_n  = 1'b0;
        drive = (cnt <= CNT_W'(DRV_LIMIT));
      end
      ST_WRECOV: drive = (cnt == CNT_W'(N_REC - 1));
      ST_RACCESS: begin
        cs_n = 1'b0;
        oe_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned T_CLK_NS = 5,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_PWE_NS = 40,
  parameter int unsigned T_SD_NS  = 25,
  parameter int unsigned T_AW_NS  = 45,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_DOE_NS = 25,
  parameter int unsigned T_HZ_NS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned C_WC  = ns_to_cyc(T_WC_NS, T_CLK_NS);
  localparam int unsigned C_PWE = ns_to_cyc(T_PWE_NS, T_CLK_NS);
  localparam int unsigned C_SD  = ns_to_cyc(T_SD_NS, T_CLK_NS);
  localparam int unsigned C_AW  = ns_to_cyc(T_AW_NS, T_CLK_NS);
  localparam int unsigned C_RC  = ns_to_cyc(T_RC_NS, T_CLK_NS);
  localparam int unsigned C_AA  = ns_to_cyc(T_AA_NS, T_CLK_NS);
  localparam int unsigned C_DOE = ns_to_cyc(T_DOE_NS, T_CLK_NS);
  localparam int unsigned C_HZ  = ns_to_cyc(T_HZ_NS, T_CLK_NS);

  // The setup cycle already has chip select low, so the pulse owes one less.
  localparam int unsigned N_PW   = max3(C_PWE, C_HZ + C_SD, (C_AW > 1) ? C_AW - 1 : 1);
  localparam int unsigned N_REC  = (C_WC > 1 + N_PW) ? C_WC - 1 - N_PW : 1;
  localparam int unsigned N_RA   = max3(C_RC, C_AA, C_DOE);
  localparam int unsigned N_TURN = C_HZ;
  localparam int unsigned MAXLEN = max3(N_PW, N_RA, max2(N_REC, N_TURN));
  localparam int unsigned CNT_W  = $clog2(MAXLEN + 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              phase_last;
  logic              accept;
  logic              wr_end_evt;
  logic              rd_capture_evt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_seq_fsm #(
    .N_PW   (N_PW),
    .N_REC  (N_REC),
    .N_RA   (N_RA),
    .N_TURN (N_TURN),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .req            (req),
    .req_write      (req_write),
    .state          (state),
    .cnt            (cnt),
    .phase_last     (phase_last),
    .accept         (accept),
    .wr_end_evt     (wr_end_evt),
    .rd_capture_evt (rd_capture_evt)
  );

  sram_pin_decode #(
    .N_PW  (N_PW),
    .N_HZ  (C_HZ),
    .N_REC (N_REC),
    .CNT_W (CNT_W)
  ) u_pins (
    .state (state),
    .cnt   (cnt),
    .cs_n  (mem_cs_n),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n),
    .drive (mem_dq_drive)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .capture (rd_capture_evt),
    .dq_in   (mem_dq_in),
    .rdata   (rsp_rdata),
    .rvalid  (rsp_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign ready      = (state == ST_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
`timescale 1ns/1ps
module sram_seq_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              ready,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_drive,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              rsp_valid,
  input logic              wr_end_evt,
  input logic              rd_capture_evt
);

  // R3
  oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R3
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_drive |-> mem_oe_n);

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_end_evt |=> (mem_dq_drive && $stable(mem_dq_out) && mem_we_n));

  // R8
  capture_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_capture_evt |=> rsp_valid);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req && ready) |=> !ready);

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sram_seq_ctrl_test;

  localparam int TP = 5;
  function automatic int cyc(input int ns);
    int c;
    c = ns / TP;
    if (c * TP < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction

  localparam int E_WC  = cyc(55);
  localparam int E_PWE = cyc(40);
  localparam int E_SD  = cyc(25);
  localparam int E_AW  = cyc(45);
  localparam int E_HZ  = cyc(20);
  localparam int E_RA  = (cyc(55) > cyc(25)) ? cyc(55) : cyc(25);
  localparam int E_PW0 = (E_PWE > E_HZ + E_SD) ? E_PWE : E_HZ + E_SD;
  localparam int E_PW  = (E_PW0 > E_AW - 1) ? E_PW0 : E_AW - 1;
  localparam int E_REC = (E_WC - 1 - E_PW > 1) ? E_WC - 1 - E_PW : 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_drive;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_in = 8'hEE;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [18:0] addr_of(input int i);
    if (i == 255) return 19'h7FFFF;
    return 19'((i << 11) | i);
  endfunction

  // Memory responder and pin timing monitor, sampled at falling edges.
  logic [7:0]  mdl [256];
  logic [7:0]  exp_mem [256];
  int          rd_cnt, drv_left, we_cnt, cs_cnt, stab_cnt, nc, last_fall;
  bit          last_wr, cur_wr, p_we_low, p_cs_low, p_drive;
  logic [7:0]  p_dq;
  logic [18:0] p_addr;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
  end

  always @(negedge clk) begin
    bit readact;
    int we_now;
    if (rst) begin
      rd_cnt = 0; drv_left = 0; we_cnt = 0; cs_cnt = 0; stab_cnt = 0; nc = 0;
      last_fall = -1000; last_wr = 0; cur_wr = 0;
      p_we_low = 0; p_cs_low = 0; p_drive = 0; p_dq = '0; p_addr = '0;
      mem_dq_in = 8'hEE;
    end else begin
      nc++;
      readact = !mem_cs_n && !mem_oe_n && mem_we_n;
      we_now  = mem_we_n ? 0 : we_cnt + 1;
      chk(!(!mem_oe_n && !mem_we_n), "R3", "oe and we low together", 1, 0);
      chk(mem_we_n || !mem_cs_n, "R3", "we low while deselected", int'(mem_cs_n), 0);
      if (mem_dq_drive) begin
        chk(mem_oe_n, "R6", "drive with oe low", int'(mem_oe_n), 1);
        chk(!readact && drv_left == 0, "R6", "drive inside memory output window", drv_left, 0);
        if (!mem_we_n) chk(we_now > E_HZ, "R6", "drive early in pulse", we_now, E_HZ + 1);
      end
      if (!mem_cs_n && !p_cs_low) begin
        if (last_wr) chk(nc - last_fall >= E_WC, "R7", "write cycle length", nc - last_fall, E_WC);
        last_fall = nc; last_wr = 0; cur_wr = 0;
      end
      if (mem_cs_n && p_cs_low && !cur_wr)
        chk(cs_cnt == E_RA, "R7", "read select length", cs_cnt, E_RA);
      if (!mem_cs_n && p_cs_low)
        chk(mem_addr == p_addr, "R4", "address moved under select", int'(mem_addr), int'(p_addr));
      if (p_we_low && mem_we_n) begin
        chk(we_cnt >= E_PWE, "R4", "write pulse width", we_cnt, E_PWE);
        chk(cs_cnt >= E_AW, "R4", "select before write end", cs_cnt, E_AW);
        chk(stab_cnt >= E_SD, "R5", "data setup", stab_cnt, E_SD);
        chk(mem_dq_drive && mem_dq_out == p_dq, "R5", "data hold", int'(mem_dq_out), int'(p_dq));
        mdl[p_addr[7:0]] = p_dq;
        last_wr = 1;
      end
      if (!mem_we_n) cur_wr = 1;
      we_cnt = we_now;
      cs_cnt = mem_cs_n ? 0 : cs_cnt + 1;
      if (mem_dq_drive && p_drive && mem_dq_out == p_dq) stab_cnt++;
      else stab_cnt = mem_dq_drive ? 1 : 0;
      drv_left = readact ? E_HZ : ((drv_left > 0) ? drv_left - 1 : 0);
      rd_cnt   = readact ? rd_cnt + 1 : 0;
      if (readact) mem_dq_in = (rd_cnt >= E_RA) ? mdl[mem_addr[7:0]] : ~mdl[mem_addr[7:0]];
      else         mem_dq_in = 8'hEE;
      p_we_low = !mem_we_n; p_cs_low = !mem_cs_n; p_drive = mem_dq_drive;
      p_dq = mem_dq_out; p_addr = mem_addr;
    end
  end

  task automatic check_idle_pins(input string tag);
    chk(mem_cs_n && mem_we_n && mem_oe_n, tag, "strobes high",
        int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
    chk(!mem_dq_drive, tag, "drive off", int'(mem_dq_drive), 0);
    chk(ready, tag, "ready high", int'(ready), 1);
    chk(!rsp_valid, tag, "valid low", int'(rsp_valid), 0);
  endtask

  task automatic do_write(input int idx, input logic [7:0] d,
                          input bit intrude, input int vidx);
    int n;
    while (!ready) @(negedge clk);
    req = 1; req_write = 1; req_addr = addr_of(idx); req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req = 0;
      if (n == 1) chk(!ready, "R2", "ready after accept", int'(ready), 0);
      if (intrude && n == 3) begin
        req = 1; req_write = 1; req_addr = addr_of(vidx); req_wdata = ~exp_mem[vidx];
      end
      if (intrude && n == 6) req = 0;
    end while (!ready);
    chk(n - 1 == 1 + E_PW + E_REC, "R9", "write busy cycles", n - 1, 1 + E_PW + E_REC);
    exp_mem[idx] = d;
  endtask

  task automatic do_read(input int idx);
    int n, rv, at;
    logic [7:0] got;
    while (!ready) @(negedge clk);
    req = 1; req_write = 0; req_addr = addr_of(idx);
    n = 0; rv = 0; at = 0; got = '0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) req = 0;
      if (rsp_valid) begin
        rv++; at = n; got = rsp_rdata;
      end
    end while (!ready);
    chk(rv == 1, "R8", "valid pulse count", rv, 1);
    chk(at == E_RA + 1, "R8", "valid cycle", at, E_RA + 1);
    chk(got == exp_mem[idx], "R8", "read data", int'(got), int'(exp_mem[idx]));
    chk(n - 1 == E_RA + 1 + E_HZ, "R9", "read busy cycles", n - 1, E_RA + 1 + E_HZ);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        chk(0, "R9", "watchdog expired", wd, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    rst = 1;
    repeat (3) begin
      @(negedge clk);
      check_idle_pins("R1");
    end
    rst = 0;
    @(negedge clk);
    check_idle_pins("R1");
    // unwritten location reads back the initial content
    do_read(5);
    for (int i = 0; i < 256; i++) do_write(i, 8'((i * 29 + 7) & 255), 0, 0);
    // a request raised while busy must leave the victim untouched
    do_write(3, 8'h3C, 1, 77);
    for (int i = 0; i < 256; i++) do_read(i);
    for (int i = 0; i < 64; i++) begin
      do_write(i * 4 + 1, ~exp_mem[i * 4 + 1], 0, 0);
      do_read(i * 4 + 1);
      do_read(i * 4 + 2);
    end
    do_read(77);
    do_write(255, 8'hFF, 0, 0);
    do_write(0, 8'h00, 0, 0);
    do_read(255);
    do_read(0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule